// File: doc/BRIEF.md
# Clock Rate Offset Corrector

This block trims the average rate of a 1 Hz timekeeping chain without touching the oscillator. Software loads an 8-bit correction word. The block then turns that word into a schedule of single-second adjustments, placed at the start of selected minutes. Each adjusted second is made shorter or longer by a whole number of prescaler ticks. The block emits one strobe per adjusted second, together with a signed tick count that the prescaler adds to the length of the second that is starting.

The correction word holds a signed count n and a mode bit. A count of n means that n units of correction are spread over one hour. One unit goes on the first second of each of the earliest minutes of the hour. Whatever exceeds what minutes 0 to 58 can take is piled onto the final minute of the hour. In normal mode only every other hour is corrected. In coarse mode every hour is corrected, so the same count has twice the effect. One normal-mode unit is worth about 2170 parts per billion. A new word is held pending and becomes active only at the next hour boundary, so an hour is never corrected by a mix of two settings.

The scheduler is a two-state machine. In state `ST_SKIP` no seconds are adjusted for the current hour. In state `ST_RUN` the minute schedule is applied. The state changes only on an hour boundary. The transition *arm* (`ST_SKIP` to `ST_RUN`) and the self-loop *keep* (`ST_RUN` to `ST_RUN`) are taken when the pending count is nonzero and the hour qualifies for the pending mode. The transition *rest* (`ST_RUN` to `ST_SKIP`) and the self-loop *idle* (`ST_SKIP` to `ST_SKIP`) are taken otherwise.

Top module: `rate_offset_corrector`

## Requirements
- R1: After reset `adj_stb` is 0 and `adj_ticks` is 0. No second is adjusted before the first hour boundary, whatever minute ticks or writes occur.
- R2: In the correction word, bits 6:0 are a two's-complement count n in the range -64..63, and bit 7 selects coarse mode (1) or normal mode (0). The amount of correction depends only on |n|.
- R3: For n > 0 an adjusted second is shortened: `adj_ticks` = -(units × STEP_TICKS). For n < 0 it is lengthened: `adj_ticks` = +(units × STEP_TICKS).
- R4: The minute index is 0 at an hour boundary and rises by 1 on each later minute tick. It saturates at 60. Minutes 0..58 each get 1 unit when their index is below |n|. Minute 59 gets |n|-59 units when |n| ≥ 60. Index 60 gets nothing. A corrected hour therefore totals |n| units.
- R5: A count of 0 (with either mode bit) produces no strobe.
- R6: A write changes only the pending word. The active word is loaded from the pending word at each hour boundary. A write in the same cycle as an hour boundary takes effect one hour later.
- R7: Hour boundaries are counted from reset. In normal mode only odd-numbered hours (1st, 3rd, ...) are corrected. In coarse mode every hour is corrected. The mode used is the one in the word that is active for that hour.
- R8: The strobe for a minute or hour tick sampled at clock edge E appears one cycle wide after edge E+1. Whenever `adj_stb` is 0, `adj_ticks` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| off_wr | input | 1 | Write strobe for the correction word |
| off_wdata | input | 8 | Correction word: bit 7 coarse mode, bits 6:0 signed count |
| min_tick | input | 1 | One-cycle pulse at the start of every minute |
| hour_tick | input | 1 | One-cycle pulse at the start of every hour; also counts as a minute start |
| adj_stb | output | 1 | One-cycle pulse: adjust the second now starting |
| adj_ticks | output | ADJ_W | Signed prescaler tick change for that second |

## Verification
Each minute or hour tick is raised at a falling edge and sampled by the next rising edge. That edge registers the minute index, the active word and the state. The strobe is registered on the edge after it, so the bench reads `adj_stb` and `adj_ticks` at the second falling edge after the tick was raised. A write reaches the active word only at the next hour tick, so the bench places writes both mid-hour and in the same cycle as an hour tick, and then compares the whole following hour. For every minute of every hour, the bench keeps its own hour count and its own active and pending words. It checks the exact tick value and also the hour's total against |n|.

// File: rtl/roc_pkg.sv
package roc_pkg;

    // scheduler states
    typedef enum logic [0:0] {
        ST_SKIP = 1'b0,
        ST_RUN  = 1'b1
    } roc_state_e;

    localparam int MINS_PER_HOUR = 60;
    localparam int LAST_MIN      = MINS_PER_HOUR - 1;
    localparam int CNT_BITS      = 7;
    localparam int MAX_MAG       = 2 ** (CNT_BITS - 1);
    localparam int MAX_TAIL      = MAX_MAG - LAST_MIN;

    // units of correction given to the first second of minute idx
    function automatic int units_for(input int mag, input int idx);
        if (idx < LAST_MIN)
            return (idx < mag) ? 1 : 0;
        if (idx == LAST_MIN && mag > LAST_MIN)
            return mag - LAST_MIN;
        return 0;
    endfunction

endpackage

// File: rtl/roc_minute_pos.sv
module roc_minute_pos #(
    parameter int MIN_SAT = 60,
    parameter int MIN_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             min_tick,
    input  logic             hour_tick,
    output logic [MIN_W-1:0] min_idx,
    output logic             odd_hr
);

    localparam logic [MIN_W-1:0] SAT_V = MIN_W'(MIN_SAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_idx <= '0;
            odd_hr  <= 1'b0;
        end else begin
            if (hour_tick) begin
                min_idx <= '0;
                odd_hr  <= ~odd_hr;
            end else if (min_tick && min_idx != SAT_V) begin
                min_idx <= min_idx + 1'b1;
            end
        end
    end

    // R4: index never passes saturation
    a_r4_idx_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        min_idx <= SAT_V);

    // R7: hour parity flips on every hour boundary
    a_r7_parity_flips: assert property (@(posedge clk) disable iff (!rst_n)
        hour_tick |=> (odd_hr != $past(odd_hr)));

endmodule

// File: rtl/roc_sched.sv
module roc_sched
    import roc_pkg::*;
#(
    parameter int STEP_TICKS = 4,
    parameter int ADJ_W      = 6,
    parameter int MIN_W      = 6,
    parameter int OFF_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    off_wr,
    input  logic [OFF_W-1:0]        off_wdata,
    input  logic                    bnd,
    input  logic                    hour_tick,
    input  logic                    odd_hr,
    input  logic [MIN_W-1:0]        min_idx,
    output logic                    adj_stb,
    output logic signed [ADJ_W-1:0] adj_ticks
);

    localparam int VAL_W = OFF_W - 1;
    localparam int SIGN  = VAL_W - 1;

    roc_state_e       st, st_nx;
    logic [OFF_W-1:0] pend, act;
    logic             evt_q;
    logic             run_ok;
    int               mag_i, units_i, amt_i;

    // next hour qualifies: nonzero count and coarse or odd-numbered hour
    assign run_ok = (pend[VAL_W-1:0] != '0) && (pend[VAL_W] || !odd_hr);

    always_comb begin
        st_nx = st;
        if (hour_tick) begin
            unique case (st)
                ST_SKIP: st_nx = run_ok ? ST_RUN : ST_SKIP;  // arm / idle
                ST_RUN:  st_nx = run_ok ? ST_RUN : ST_SKIP;  // keep / rest
                default: st_nx = ST_SKIP;
            endcase
        end
    end

    always_comb begin
        if (act[SIGN])
            mag_i = -int'($signed(act[VAL_W-1:0]));
        else
            mag_i = int'(act[VAL_W-1:0]);
        units_i = units_for(mag_i, int'(min_idx));
        amt_i   = units_i * STEP_TICKS;
    end

    // state register and word holding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_SKIP;
            pend  <= '0;
            act   <= '0;
            evt_q <= 1'b0;
        end else begin
            st    <= st_nx;
            evt_q <= bnd;
            if (hour_tick)
                act <= pend;
            if (off_wr)
                pend <= off_wdata;
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adj_stb   <= 1'b0;
            adj_ticks <= '0;
        end else if (evt_q && st == ST_RUN && units_i != 0) begin
            adj_stb   <= 1'b1;
            adj_ticks <= act[SIGN] ? ADJ_W'(amt_i) : ADJ_W'(-amt_i);
        end else begin
            adj_stb   <= 1'b0;
            adj_ticks <= '0;
        end
    end

    // R3: shortening for positive counts, lengthening for negative
    a_r3_sign_matches: assert property (@(posedge clk) disable iff (!rst_n)
        adj_stb |-> (adj_ticks[ADJ_W-1] == ~$past(act[SIGN])));

    // R5: zero count never adjusts
    a_r5_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(act[VAL_W-1:0]) == '0) |-> !adj_stb);

    // R6: active word changes only on hour boundaries
    a_r6_act_held: assert property (@(posedge clk) disable iff (!rst_n)
        !hour_tick |=> $stable(act));

endmodule

// File: rtl/rate_offset_corrector.sv
module rate_offset_corrector
    import roc_pkg::*;
#(
    parameter int STEP_TICKS = 4,
    parameter int ADJ_W      = $clog2(MAX_TAIL * STEP_TICKS + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    off_wr,
    input  logic [7:0]              off_wdata,
    input  logic                    min_tick,
    input  logic                    hour_tick,
    output logic                    adj_stb,
    output logic signed [ADJ_W-1:0] adj_ticks
);

    localparam int MIN_SAT = MINS_PER_HOUR;
    localparam int MIN_W   = $clog2(MIN_SAT + 1);

    logic [MIN_W-1:0] min_idx;
    logic             odd_hr;
    logic             bnd;

    assign bnd = min_tick | hour_tick;

    roc_minute_pos #(
        .MIN_SAT (MIN_SAT),
        .MIN_W   (MIN_W)
    ) pos_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .min_tick  (min_tick),
        .hour_tick (hour_tick),
        .min_idx   (min_idx),
        .odd_hr    (odd_hr)
    );

    roc_sched #(
        .STEP_TICKS (STEP_TICKS),
        .ADJ_W      (ADJ_W),
        .MIN_W      (MIN_W),
        .OFF_W      (8)
    ) sched_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .off_wr    (off_wr),
        .off_wdata (off_wdata),
        .bnd       (bnd),
        .hour_tick (hour_tick),
        .odd_hr    (odd_hr),
        .min_idx   (min_idx),
        .adj_stb   (adj_stb),
        .adj_ticks (adj_ticks)
    );

    // R8: a strobe follows a minute or hour tick by two edges
    a_r8_strobe_latency: assert property (@(posedge clk) disable iff (!rst_n)
        adj_stb |-> $past(min_tick | hour_tick, 2));

    // R8: quiet output carries no tick count
    a_r8_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !adj_stb |-> (adj_ticks == '0));

endmodule

// File: tb/rate_offset_corrector_tb_top.sv
module rate_offset_corrector_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int STEP       = 4;
    localparam int ADJ_W      = $clog2(5 * STEP + 1) + 1;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    off_wr = 1'b0;
    logic [7:0]              off_wdata = '0;
    logic                    min_tick = 1'b0;
    logic                    hour_tick = 1'b0;
    logic                    adj_stb;
    logic signed [ADJ_W-1:0] adj_ticks;

    int total = 0;
    int bad   = 0;
    int hcount = 0;
    logic [7:0] pend_v = '0;
    logic [7:0] act_v  = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rate_offset_corrector #(.STEP_TICKS(STEP), .ADJ_W(ADJ_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .off_wr    (off_wr),
        .off_wdata (off_wdata),
        .min_tick  (min_tick),
        .hour_tick (hour_tick),
        .adj_stb   (adj_stb),
        .adj_ticks (adj_ticks)
    );

    task automatic check(input bit ok, input string req, input int actv, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actv, expv);
        end
    endtask

    function automatic int cnt_of(input logic [7:0] w);
        return int'($signed(w[6:0]));
    endfunction

    // expected units per minute, straight from R4
    function automatic int exp_units(input int n, input int idx);
        int m;
        m = (n < 0) ? -n : n;
        if (idx <= 58) return (idx < m) ? 1 : 0;
        if (idx == 59) return (m >= 60) ? m - 59 : 0;
        return 0;
    endfunction

    task automatic write_word(input logic [7:0] v);
        off_wr    = 1'b1;
        off_wdata = v;
        @(negedge clk);
        off_wr    = 1'b0;
        pend_v    = v;
    endtask

    // one minute tick; optional write in the same cycle; samples result
    task automatic tick(input bit hr, input bit wr, input logic [7:0] wv,
                        output logic stb, output int tks);
        min_tick  = 1'b1;
        hour_tick = hr;
        off_wr    = wr;
        off_wdata = wv;
        @(negedge clk);
        min_tick  = 1'b0;
        hour_tick = 1'b0;
        off_wr    = 1'b0;
        @(negedge clk);
        stb = adj_stb;
        tks = int'(adj_ticks);
    endtask

    // one full hour: 60 minutes plus one tick past saturation
    task automatic run_hour(input string req, input bit wr_hr, input logic [7:0] wv_hr,
                            input int wr_min, input logic [7:0] wv_min);
        logic stb;
        int   tks, n, u, exp_t, sum, exp_sum;
        bit   corrected;
        hcount++;
        act_v = pend_v;
        if (wr_hr) pend_v = wv_hr;
        n = cnt_of(act_v);
        corrected = (n != 0) && (act_v[7] || (hcount % 2 == 1));
        sum = 0;
        exp_sum = corrected ? ((n < 0) ? -n : n) * STEP : 0;
        for (int k = 0; k <= 60; k++) begin
            if (k == wr_min) write_word(wv_min);
            tick(k == 0, (k == 0) && wr_hr, wv_hr, stb, tks);
            u = corrected ? exp_units(n, k) : 0;
            exp_t = (u == 0) ? 0 : ((n > 0) ? -u * STEP : u * STEP);
            check(stb == (u != 0), req, int'(stb), int'(u != 0));
            check(tks == exp_t, req, tks, exp_t);
            sum += (tks < 0) ? -tks : tks;
        end
        check(sum == exp_sum, {req, " R4 hour total"}, sum, exp_sum);
    endtask

    task automatic t_reset;
        check(adj_stb == 1'b0, "R1 reset stb", int'(adj_stb), 0);
        check(adj_ticks == '0, "R1 reset ticks", int'(adj_ticks), 0);
    endtask

    task automatic t_before_hour;
        logic stb;
        int   tks;
        write_word(8'h03);
        for (int k = 0; k < 3; k++) begin
            tick(1'b0, 1'b0, 8'h00, stb, tks);
            check(stb == 1'b0, "R1 no strobe before first hour", int'(stb), 0);
        end
    endtask

    task automatic t_normal_positive;
        run_hour("R2 R3 R4 R7 normal +3 hour1", 1'b0, 8'h00, -1, 8'h00);
        run_hour("R7 normal skip hour2", 1'b0, 8'h00, -1, 8'h00);
    endtask

    task automatic t_negative_tail;
        write_word(8'h42);
        run_hour("R3 R4 R6 normal -62 hour3 midhour write", 1'b0, 8'h00, 10, 8'h85);
    endtask

    task automatic t_coarse;
        run_hour("R7 coarse +5 hour4", 1'b0, 8'h00, -1, 8'h00);
        run_hour("R7 coarse +5 hour5", 1'b0, 8'h00, -1, 8'h00);
    endtask

    task automatic t_write_at_boundary;
        run_hour("R6 write with hour tick hour6", 1'b1, 8'h40, -1, 8'h00);
        run_hour("R4 normal -64 hour7", 1'b0, 8'h00, -1, 8'h00);
    endtask

    task automatic t_max_positive;
        write_word(8'h3F);
        run_hour("R7 normal +63 skip hour8", 1'b0, 8'h00, -1, 8'h00);
        run_hour("R3 R4 normal +63 hour9", 1'b0, 8'h00, -1, 8'h00);
    endtask

    task automatic t_zero;
        write_word(8'h00);
        run_hour("R5 zero normal hour10", 1'b0, 8'h00, -1, 8'h00);
        run_hour("R5 zero normal hour11", 1'b0, 8'h00, -1, 8'h00);
        write_word(8'h80);
        run_hour("R5 zero coarse hour12", 1'b0, 8'h00, -1, 8'h00);
    endtask

    // R8 latency: nothing one edge after the tick, strobe after the second edge
    task automatic t_latency;
        write_word(8'h81);
        run_hour("R8 coarse +1 hour13", 1'b0, 8'h00, -1, 8'h00);
        hcount++;
        act_v = pend_v;
        min_tick  = 1'b1;
        hour_tick = 1'b1;
        @(negedge clk);
        min_tick  = 1'b0;
        hour_tick = 1'b0;
        check(adj_stb == 1'b0, "R8 no strobe after first edge", int'(adj_stb), 0);
        @(negedge clk);
        check(adj_stb == 1'b1, "R8 strobe after second edge", int'(adj_stb), 1);
        check(int'(adj_ticks) == -STEP, "R8 R3 value", int'(adj_ticks), -STEP);
        @(negedge clk);
        check(adj_stb == 1'b0, "R8 one cycle wide", int'(adj_stb), 0);
        check(adj_ticks == '0, "R8 quiet ticks zero", int'(adj_ticks), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_before_hour();
        t_normal_positive();
        t_negative_tail();
        t_coarse();
        t_write_at_boundary();
        t_max_positive();
        t_zero();
        t_latency();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule